// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block derives a slower clock from its input clock. The high time and the low time are set independently in whole input cycles, so any split of a given ratio is possible. A sync strobe restarts the waveform at a chosen level. The first transition after the strobe can be held back by a coarse offset counted in input cycles.

For odd ratios whose low count is exactly one more than the high count, an optional correction stage stretches each high phase by half an input cycle. This gives an exact 50% duty cycle. A bypass control sends the input clock straight to the output for a ratio of one. Divider outputs that share an input clock are aligned by pulsing their sync strobes in the same cycle.

Top module: `ckdiv_top`

## Requirements
- R1: The output period is D = N + M + 2 input cycles, where N is `hi_cnt_i` and M is `lo_cnt_i`. Both are 4-bit values, so every setting gives a ratio from 2 to 32 and no setting is out of range.
- R2: With correction inactive, every high phase lasts N + 1 input cycles and every low phase lasts M + 1 input cycles, for any split of D.
- R3: A sync strobe `sync_i` sampled high at a rising clock edge restarts the divider. From the half-cycle after that edge, the output shows the level chosen by `start_hi_i`.
- R4: After a sync, the first segment is lengthened by `phase_i` input cycles (0 to 31). Throughout that time the output holds the start level.
- R5: With `start_hi_i` = 1 the first segment after sync is high for `phase_i` + N + 1 cycles. With `start_hi_i` = 0 it is low for `phase_i` + M + 1 cycles. After that, phases alternate.
- R6: When `dcc_en_i` = 1 and M = N + 1, each high phase lasts N + 1.5 input cycles and each low phase lasts N + 1.5 input cycles. When M differs from N + 1, `dcc_en_i` has no effect on the output.
- R7: With `bypass_i` = 1, `clk_o` equals `clk_i`.
- R8: While `rst_ni` is low, `clk_o` is low (bypass off). After release, the divider starts low and rises M + 1 rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Restart strobe, sampled on the rising edge |
| hi_cnt_i | input | 4 | High phase length minus one (N) |
| lo_cnt_i | input | 4 | Low phase length minus one (M) |
| phase_i | input | 5 | Start offset in input cycles |
| start_hi_i | input | 1 | Level of the first segment after sync |
| dcc_en_i | input | 1 | Enable half-cycle duty correction |
| bypass_i | input | 1 | Pass the input clock straight through |
| clk_o | output | 1 | Divided clock |

## Verification
A phase counter that is off by one shows up at the port as a high or low width that is one cycle wrong. It appears within one period after the first segment. A stale offset count or a wrong start level distorts the first segment right after sync. The correction stage is checked at half-cycle resolution: a wrong edge choice moves a transition by half a cycle in the first full period. The bench sweeps every (N, M) pair with both start levels and with correction on and off. It compares each half-cycle sample against a waveform model, so any of these faults shows up within one or two periods of the output.

// File: rtl/ckdiv_pkg.sv
package ckdiv_pkg;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned PH_W  = 5;
  localparam int unsigned MAX_RATIO = 2 * (1 << CNT_W);
endpackage

// File: rtl/ckdiv_offset.sv
module ckdiv_offset #(
  parameter int unsigned PH_W = ckdiv_pkg::PH_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            hold_o
);
  logic [PH_W-1:0] dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             dly_q <= '0;
    else if (load_i)         dly_q <= phase_i;
    else if (dly_q != '0)    dly_q <= dly_q - 1'b1;
  end

  assign hold_o = |dly_q;
endmodule

// File: rtl/ckdiv_level.sv
module ckdiv_level #(
  parameter int unsigned CNT_W = ckdiv_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             start_hi_i,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             level_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic [CNT_W-1:0] limit;

  assign limit = lvl_q ? hi_i : lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= '0;
      lvl_q <= start_hi_i;
    end else if (!hold_i) begin
      if (cnt_q == limit) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/ckdiv_shape.sv
module ckdiv_shape #(
  parameter bit HALF_STRETCH = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  input  logic dcc_act_i,
  input  logic bypass_i,
  output logic clk_o
);
  logic shaped;

  generate
    if (HALF_STRETCH) begin : g_stretch
      logic neg_q;
      // copy taken on the falling edge holds a falling level for half a cycle
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) neg_q <= 1'b0;
        else         neg_q <= level_i;
      end
      assign shaped = level_i | (dcc_act_i & neg_q);
    end else begin : g_plain
      logic unused_act;
      assign unused_act = dcc_act_i;
      assign shaped     = level_i;
    end
  endgenerate

  assign clk_o = bypass_i ? clk_i : shaped;
endmodule

// File: rtl/ckdiv_top.sv
module ckdiv_top #(
  parameter int unsigned CNT_W        = ckdiv_pkg::CNT_W,
  parameter int unsigned PH_W         = ckdiv_pkg::PH_W,
  parameter bit          HALF_STRETCH = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CNT_W-1:0] hi_cnt_i,
  input  logic [CNT_W-1:0] lo_cnt_i,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             start_hi_i,
  input  logic             dcc_en_i,
  input  logic             bypass_i,
  output logic             clk_o
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic hold;
  logic level;
  logic dcc_act;

  // correction only meaningful for odd ratio with M = N + 1
  assign dcc_act = dcc_en_i &&
                   ({1'b0, lo_cnt_i} == ({1'b0, hi_cnt_i} + EXT_W'(1)));

  ckdiv_offset #(.PH_W(PH_W)) u_offset (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sync_i),
    .phase_i (phase_i),
    .hold_o  (hold)
  );

  ckdiv_level #(.CNT_W(CNT_W)) u_level (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (sync_i),
    .start_hi_i (start_hi_i),
    .hold_i     (hold),
    .hi_i       (hi_cnt_i),
    .lo_i       (lo_cnt_i),
    .level_o    (level)
  );

  ckdiv_shape #(.HALF_STRETCH(HALF_STRETCH)) u_shape (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .level_i   (level),
    .dcc_act_i (dcc_act),
    .bypass_i  (bypass_i),
    .clk_o     (clk_o)
  );
endmodule

// File: rtl/ckdiv_chk.sv
module ckdiv_chk #(
  parameter int unsigned CNT_W = ckdiv_pkg::CNT_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic             start_hi_i,
  input logic             hold_i,
  input logic [CNT_W-1:0] hi_i,
  input logic [CNT_W-1:0] lo_i,
  input logic [CNT_W-1:0] cnt_q,
  input logic             lvl_q
);
  // R3
  sync_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lvl_q == $past(start_hi_i)));

  // R4
  offset_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !load_i) |=> $stable(lvl_q));

  // R2
  hi_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && lvl_q) |-> (cnt_q <= hi_i));

  // R2
  lo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !lvl_q) |-> (cnt_q <= lo_i));
endmodule

bind ckdiv_level ckdiv_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_i     (load_i),
  .start_hi_i (start_hi_i),
  .hold_i     (hold_i),
  .hi_i       (hi_i),
  .lo_i       (lo_i),
  .cnt_q      (cnt_q),
  .lvl_q      (lvl_q)
);

// File: tb/tb_ckdiv_top.sv
module tb_ckdiv_top;
  localparam int T_CLK = 20;
  localparam int T_HALF = T_CLK / 2;
  localparam int T_QTR = T_CLK / 4;
  localparam int WDOG = 190000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [3:0] hi_cnt_i = '0;
  logic [3:0] lo_cnt_i = '0;
  logic [4:0] phase_i = '0;
  logic       start_hi_i = 1'b0;
  logic       dcc_en_i = 1'b0;
  logic       bypass_i = 1'b0;
  logic       clk_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(T_HALF) clk_i = ~clk_i;

  ckdiv_top dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i),
    .hi_cnt_i(hi_cnt_i), .lo_cnt_i(lo_cnt_i), .phase_i(phase_i),
    .start_hi_i(start_hi_i), .dcc_en_i(dcc_en_i), .bypass_i(bypass_i),
    .clk_o(clk_o)
  );

  // divided level in cycle c after the sync edge
  function automatic bit lvl_model(int c, int n, int m, int p, bit st);
    int l0 = p + (st ? n + 1 : m + 1);
    int l1 = st ? m + 1 : n + 1;
    int d  = n + m + 2;
    if (c < l0) return st;
    return (((c - l0) % d) < l1) ? ~st : st;
  endfunction

  // output at half-cycle sample k (k even: after rising edge)
  function automatic bit out_model(int k, int n, int m, int p, bit st, bit act);
    int c = k / 2;
    if (act && (k % 2 == 0) && k > 0)
      return lvl_model(c, n, m, p, st) | lvl_model(c - 1, n, m, p, st);
    return lvl_model(c, n, m, p, st);
  endfunction

  task automatic check(string tag, bit act_v, bit exp_v, string what);
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act_v, exp_v);
    end
  endtask

  task automatic run_cfg(int n, int m, int p, bit st, bit dcc);
    bit act = dcc && (m == n + 1);
    int d = n + m + 2;
    int l0 = p + (st ? n + 1 : m + 1);
    int ks = 2 * (l0 + 2 * d + 1);
    bit bad_a = 0, bad_b = 0;
    bit got_a = 0, exp_a = 0, got_b = 0, exp_b = 0;
    @(negedge clk_i);
    hi_cnt_i = 4'(n); lo_cnt_i = 4'(m); phase_i = 5'(p);
    start_hi_i = st; dcc_en_i = dcc; sync_i = 1'b1;
    @(posedge clk_i);
    #(T_QTR);
    sync_i = 1'b0;
    for (int k = 0; k < ks; k++) begin
      if (k > 0) #(T_HALF);
      if (act && k == 0) continue;
      if (k < 2 * l0) begin
        if (!bad_a && clk_o !== out_model(k, n, m, p, st, act)) begin
          bad_a = 1; got_a = clk_o; exp_a = out_model(k, n, m, p, st, act);
        end
      end else begin
        if (!bad_b && clk_o !== out_model(k, n, m, p, st, act)) begin
          bad_b = 1; got_b = clk_o; exp_b = out_model(k, n, m, p, st, act);
        end
      end
    end
    // R3 R4 R5: first segment after sync
    check("R3/R4/R5", bad_a ? got_a : 1'b0, bad_a ? exp_a : 1'b0,
          $sformatf("first segment n=%0d m=%0d p=%0d st=%0b dcc=%0b", n, m, p, st, dcc));
    // R1 R2 R6: steady period and duty
    check(act ? "R6" : "R1/R2", bad_b ? got_b : 1'b0, bad_b ? exp_b : 1'b0,
          $sformatf("steady wave n=%0d m=%0d p=%0d st=%0b dcc=%0b", n, m, p, st, dcc));
  endtask

  initial begin
    repeat (WDOG) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c1d));
    hi_cnt_i = 4'd2; lo_cnt_i = 4'd3;
    repeat (3) @(posedge clk_i);
    #(T_QTR);
    check("R8", clk_o, 1'b0, "output during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(posedge clk_i);
    #(T_QTR);
    check("R8", clk_o, 1'b0, "low before M+1 edges after reset");
    @(posedge clk_i);
    #(T_QTR);
    check("R8", clk_o, 1'b1, "rise at M+1 edges after reset");

    // R7: bypass follows input clock
    @(negedge clk_i);
    bypass_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_i);
      #(T_QTR);
      check("R7", clk_o, 1'b1, "bypass high half");
      #(T_HALF);
      check("R7", clk_o, 1'b0, "bypass low half");
    end
    @(negedge clk_i);
    bypass_i = 1'b0;

    // directed corners
    run_cfg(0, 0, 0, 1'b1, 1'b0);
    run_cfg(15, 15, 31, 1'b0, 1'b0);
    run_cfg(0, 1, 0, 1'b1, 1'b1);
    run_cfg(14, 15, 31, 1'b0, 1'b1);
    run_cfg(1, 3, 0, 1'b1, 1'b0);
    run_cfg(3, 1, 0, 1'b0, 1'b0);

    // sweep every split, both start levels, correction on and off
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++)
        for (int v = 0; v < 4; v++)
          run_cfg(n, m, int'($urandom % 32), v[0], v[1]);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule